// File: doc/BRIEF.md
# Guard-cell cell-averaging CFAR detector

This block sets a detection threshold that adapts to the interference level around each range cell. The input is a stream of power values (squared magnitudes) in range order. Each range line belongs to one Doppler channel. For each cell under test, the block adds up the powers in a sliding window that reaches M/2 cells on either side of the test cell. Three cells are left out of that sum: the test cell itself and its two immediate neighbours. This keeps energy from a target that straddles two cells out of the estimate.

The reference sum is divided by M−3 to give the interference estimate. A cell is declared a detection when its power is strictly greater than a programmable fixed-point multiple of that estimate. Holding the multiplier fixed holds the false-alarm rate roughly constant while the interference level changes. The comparison is done by cross-multiplication, so no divider sits in the decision path.

The zero-Doppler channel carries stationary clutter. It is passed through without any detection. Cells close to the start of a line have an incomplete window. Those cells are reported but marked not valid, and they never detect.

Top module: `cfar_gc_detector`

## Requirements
- R1: After reset, out_valid, out_det and out_full are 0 and out_est is 0 until the first output is produced.
- R2: A cell accepted with in_first high gets line index 0. Each later accepted cell gets the previous index plus one. A cell accepted at index j ≥ H (H = M/2) produces exactly one output, for test cell j−H. That output has out_valid high for one cycle, registered on the clock edge after the edge that accepted cell j. Outputs appear in increasing index order, and the last H cells of a line are never reported.
- R3: The reference sum for test cell t is the sum of the powers at indices t+o, where o runs from −H to −2 and from +2 to +H. That is M−2 cells; offsets −1, 0 and +1 never contribute.
- R4: For a nonzero channel, out_est equals the reference sum divided by M−3, rounded down.
- R5: For a nonzero channel with a complete window, out_det is 1 exactly when power·(M−3)·2^FW > alpha·refsum. Alpha is an unsigned AW-bit value with FW fractional bits. Equality gives no detection.
- R6: When the test index is below H, out_full is 0 and out_det is 0. out_est is still formed from the cells present, with cells before index 0 counted as zero.
- R7: The channel of a line is the in_chan value on its in_first cell; in_chan on later cells is ignored. For channel 0, out_det and out_est are 0 for every reported cell, and out_chan reports 0.
- R8: A new in_first cell restarts the line. No power from an earlier line enters any sum of the new line.
- R9: Idle cycles (in_valid low) between cells of a line change neither the output values nor the number of outputs.
- R10: Alpha is sampled on the in_first cell and applies to the whole line. Changes to thr_alpha on later cells have no effect on that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input cell present this cycle |
| in_first | input | 1 | Input cell is index 0 of a new range line |
| in_chan | input | CH_W | Doppler channel tag, taken on the first cell |
| in_power | input | PW | Cell power (squared magnitude) |
| thr_alpha | input | AW | Threshold multiplier, FW fractional bits, taken on the first cell |
| out_valid | output | 1 | Output fields hold a reported cell |
| out_idx | output | IDX_W | Range index of the reported test cell |
| out_chan | output | CH_W | Channel of the reported cell |
| out_full | output | 1 | Reference window was complete |
| out_det | output | 1 | Detection flag |
| out_est | output | PW+clog2(M+1) | Interference estimate, refsum/(M−3) |

## Verification
The hardest case to reach from the ports is the exact threshold boundary, where power·(M−3)·2^FW equals alpha·refsum. Random powers almost never land on it. A directed line fixes every reference cell to one value and picks alpha and two spike powers so that one spike sits exactly on the boundary and the other sits one step above it. The bench also drives lines with random idle gaps, and mid-line changes to alpha and to the channel tag. These check that only the first cell's values count. A bright line followed at once by a dim one shows whether any stale window contents leak across a restart.

// File: rtl/cfar_pkg.sv
package cfar_pkg;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // bits needed to hold the value v
   function automatic int bits_for(input int v);
      return $clog2(v + 1);
   endfunction

endpackage

// File: rtl/cfar_window.sv
// Sliding range window: shift register of M+1 cells with a running total.
module cfar_window #(
   parameter int PW = 16,
   parameter int M  = 16,
   parameter int SW = 21
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          shift_en,
   input  logic          restart,
   input  logic [PW-1:0] din,
   output logic [PW-1:0] guard_lo,   // offset -1 (older neighbour)
   output logic [PW-1:0] guard_mid,  // offset 0 (cell under test)
   output logic [PW-1:0] guard_hi,   // offset +1 (newer neighbour)
   output logic [SW-1:0] sum_all
);
   localparam int H = M / 2;

   logic [M:0][PW-1:0] taps;   // taps[0] newest, taps[M] oldest
   logic [SW-1:0]      tap_total;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         taps    <= '0;
         sum_all <= '0;
      end else if (shift_en) begin
         for (int k = M; k >= 1; k--) begin
            taps[k] <= restart ? '0 : taps[k-1];
         end
         taps[0] <= din;
         sum_all <= restart ? SW'(din)
                            : sum_all + SW'(din) - SW'(taps[M]);
      end
   end

   assign guard_hi  = taps[H-1];
   assign guard_mid = taps[H];
   assign guard_lo  = taps[H+1];

   always_comb begin
      tap_total = '0;
      for (int k = 0; k <= M; k++) begin
         tap_total = tap_total + SW'(taps[k]);
      end
   end

   // R3: running total stays equal to the window contents
   a_r3_sum_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      sum_all == tap_total);

   // R9: an idle cycle leaves the window total untouched
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sum_all));

endmodule

// File: rtl/cfar_seq.sv
// Line sequencing: range index of newest cell, per-line channel and alpha.
module cfar_seq #(
   parameter int IDX_W = 8,
   parameter int CH_W  = 3,
   parameter int AW    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_first,
   input  logic [CH_W-1:0]  in_chan,
   input  logic [AW-1:0]    in_alpha,
   output logic             stage_v,
   output logic [IDX_W-1:0] newest_idx,
   output logic [CH_W-1:0]  line_chan,
   output logic [AW-1:0]    line_alpha
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_v    <= 1'b0;
         newest_idx <= '0;
         line_chan  <= '0;
         line_alpha <= '0;
      end else begin
         stage_v <= in_valid;
         if (in_valid) begin
            if (in_first) begin
               newest_idx <= '0;
               line_chan  <= in_chan;
               line_alpha <= in_alpha;
            end else begin
               newest_idx <= newest_idx + 1'b1;
            end
         end
      end
   end

   // R8: a first cell always restarts the index
   a_r8_restart_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_first) |=> (newest_idx == '0));

   // R10: alpha only moves on a first cell
   a_r10_alpha_held: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_first) |=> $stable(line_alpha));

endmodule

// File: rtl/cfar_decide.sv
// Reference sum, normalised estimate and cross-multiplied threshold test.
module cfar_decide #(
   parameter int PW    = 16,
   parameter int M     = 16,
   parameter int SW    = 21,
   parameter int AW    = 8,
   parameter int FW    = 4,
   parameter int IDX_W = 8,
   parameter int CH_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             stage_v,
   input  logic [IDX_W-1:0] newest_idx,
   input  logic [CH_W-1:0]  line_chan,
   input  logic [AW-1:0]    line_alpha,
   input  logic [PW-1:0]    guard_lo,
   input  logic [PW-1:0]    guard_mid,
   input  logic [PW-1:0]    guard_hi,
   input  logic [SW-1:0]    sum_all,
   output logic             out_valid,
   output logic [IDX_W-1:0] out_idx,
   output logic [CH_W-1:0]  out_chan,
   output logic             out_full,
   output logic             out_det,
   output logic [SW-1:0]    out_est
);
   localparam int H    = M / 2;
   localparam int NORM = M - 3;
   localparam int KMUL = NORM << FW;
   localparam int KW   = cfar_pkg::bits_for(KMUL);
   localparam int CW   = cfar_pkg::imax(PW + KW, AW + SW) + 1;

   logic [SW-1:0]    ref_sum;
   logic [CW-1:0]    lhs, rhs;
   logic             emit, full, clutter_ch, hit;
   logic [IDX_W-1:0] test_idx;
   logic [SW-1:0]    est;

   always_comb begin
      ref_sum    = sum_all - SW'(guard_lo) - SW'(guard_mid) - SW'(guard_hi);
      emit       = stage_v && (newest_idx >= IDX_W'(H));
      full       = newest_idx >= IDX_W'(M);
      test_idx   = newest_idx - IDX_W'(H);
      clutter_ch = (line_chan == '0);
      lhs        = CW'(guard_mid) * CW'(KMUL);
      rhs        = CW'(line_alpha) * CW'(ref_sum);
      hit        = full && !clutter_ch && (lhs > rhs);
      est        = clutter_ch ? '0 : (ref_sum / SW'(NORM));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_idx   <= '0;
         out_chan  <= '0;
         out_full  <= 1'b0;
         out_det   <= 1'b0;
         out_est   <= '0;
      end else begin
         out_valid <= emit;
         out_det   <= emit && hit;
         if (emit) begin
            out_idx  <= test_idx;
            out_chan <= line_chan;
            out_full <= full;
            out_est  <= est;
         end
      end
   end

endmodule

// File: rtl/cfar_gc_detector.sv
module cfar_gc_detector #(
   parameter int PW    = 16,
   parameter int M     = 16,
   parameter int AW    = 8,
   parameter int FW    = 4,
   parameter int IDX_W = 8,
   parameter int CH_W  = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         in_valid,
   input  logic                         in_first,
   input  logic [CH_W-1:0]              in_chan,
   input  logic [PW-1:0]                in_power,
   input  logic [AW-1:0]                thr_alpha,
   output logic                         out_valid,
   output logic [IDX_W-1:0]             out_idx,
   output logic [CH_W-1:0]              out_chan,
   output logic                         out_full,
   output logic                         out_det,
   output logic [PW+$clog2(M+1)-1:0]    out_est
);
   localparam int H  = M / 2;
   localparam int SW = PW + $clog2(M + 1);

   generate
      if ((M % 2) != 0 || M < 4) begin : g_bad_m
         $error("cfar_gc_detector: M must be even and at least 4");
      end
      if ((1 << IDX_W) <= M) begin : g_bad_idx
         $error("cfar_gc_detector: IDX_W too small for window");
      end
      if (FW >= AW) begin : g_bad_fw
         $error("cfar_gc_detector: FW must be below AW");
      end
   endgenerate

   logic             stage_v;
   logic [IDX_W-1:0] newest_idx;
   logic [CH_W-1:0]  line_chan;
   logic [AW-1:0]    line_alpha;
   logic [PW-1:0]    guard_lo, guard_mid, guard_hi;
   logic [SW-1:0]    sum_all;

   cfar_seq #(.IDX_W(IDX_W), .CH_W(CH_W), .AW(AW)) i_seq (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_chan(in_chan), .in_alpha(thr_alpha), .stage_v(stage_v),
      .newest_idx(newest_idx), .line_chan(line_chan), .line_alpha(line_alpha)
   );

   cfar_window #(.PW(PW), .M(M), .SW(SW)) i_window (
      .clk(clk), .rst_n(rst_n), .shift_en(in_valid),
      .restart(in_valid && in_first), .din(in_power),
      .guard_lo(guard_lo), .guard_mid(guard_mid), .guard_hi(guard_hi),
      .sum_all(sum_all)
   );

   cfar_decide #(.PW(PW), .M(M), .SW(SW), .AW(AW), .FW(FW),
                 .IDX_W(IDX_W), .CH_W(CH_W)) i_decide (
      .clk(clk), .rst_n(rst_n), .stage_v(stage_v), .newest_idx(newest_idx),
      .line_chan(line_chan), .line_alpha(line_alpha),
      .guard_lo(guard_lo), .guard_mid(guard_mid), .guard_hi(guard_hi),
      .sum_all(sum_all),
      .out_valid(out_valid), .out_idx(out_idx), .out_chan(out_chan),
      .out_full(out_full), .out_det(out_det), .out_est(out_est)
   );

   // R6: no detection without a complete window or a reported cell
   a_r6_full_gate: assert property (@(posedge clk) disable iff (!rst_n)
      out_det |-> (out_valid && out_full));

   // R7: zero-Doppler channel never detects and reports no estimate
   a_r7_zero_chan: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_chan == '0) |-> (!out_det && out_est == '0));

   // R2: an incomplete window only occurs at the leading edge of a line
   a_r2_partial_idx: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_full) |-> (out_idx < IDX_W'(H)));

   // R2: a reported cell needs an accepted cell on the previous edge
   a_r2_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(in_valid, 2));

endmodule

// File: tb/test_cfar_gc_detector.sv
module test_cfar_gc_detector;
   localparam int PW = 16, M = 16, AW = 8, FW = 4, IDX_W = 8, CH_W = 3;
   localparam int H = M / 2;
   localparam int SW = PW + $clog2(M + 1);
   localparam longint KMUL = longint'(M - 3) << FW;

   logic clk = 1'b0, rst_n = 1'b0;
   logic in_valid = 1'b0, in_first = 1'b0;
   logic [CH_W-1:0] in_chan = '0;
   logic [PW-1:0] in_power = '0;
   logic [AW-1:0] thr_alpha = '0;
   logic out_valid, out_full, out_det;
   logic [IDX_W-1:0] out_idx;
   logic [CH_W-1:0] out_chan;
   logic [SW-1:0] out_est;

   cfar_gc_detector #(.PW(PW), .M(M), .AW(AW), .FW(FW), .IDX_W(IDX_W), .CH_W(CH_W))
      i_cfar_gc_detector (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
      .in_chan(in_chan), .in_power(in_power), .thr_alpha(thr_alpha),
      .out_valid(out_valid), .out_idx(out_idx), .out_chan(out_chan),
      .out_full(out_full), .out_det(out_det), .out_est(out_est));

   always #5 clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   bit done = 1'b0;
   longint pw [0:127];
   int cur_len = 0, cur_ch = 0, cur_alpha = 0, next_idx = 0, nout = 0;
   bit obs_det [0:127];

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic longint ref_of(input int t);
      longint s = 0;
      for (int o = -H; o <= H; o++)
         if ((o < -1 || o > 1) && t + o >= 0 && t + o < cur_len) s += pw[t + o];
      return s;
   endfunction

   // output monitor: compares every reported cell with the model
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         int t;
         longint r, e_est;
         bit e_full, e_det;
         t = next_idx;
         r = ref_of(t);
         e_full = (t >= H);
         e_est = (cur_ch == 0) ? 0 : r / (M - 3);
         e_det = e_full && cur_ch != 0 && (pw[t] * KMUL > longint'(cur_alpha) * r);
         chk(out_idx == IDX_W'(t), "R2 index order", out_idx, t);
         chk(out_chan == CH_W'(cur_ch), "R7 channel", out_chan, cur_ch);
         chk(out_full == e_full, "R6 full flag", out_full, e_full);
         chk(out_est == SW'(e_est), (cur_ch == 0) ? "R7 estimate" : "R3/R4 estimate",
             out_est, e_est);
         chk(out_det == e_det, !e_full ? "R6 det" : (cur_ch == 0 ? "R7 det" : "R5 det"),
             out_det, e_det);
         obs_det[t] = out_det;
         next_idx++;
         nout++;
      end
   end

   task automatic run_line(input int len, input int ch, input int alpha,
                           input bit gaps, input bit wiggle);
      cur_len = len; cur_ch = ch; cur_alpha = alpha; next_idx = 0; nout = 0;
      for (int i = 0; i < 128; i++) obs_det[i] = 1'b0;
      for (int i = 0; i < len; i++) begin
         if (gaps && ($urandom % 3 == 0)) begin
            in_valid = 1'b0;
            repeat (1 + $urandom % 3) @(negedge clk);
         end
         in_valid = 1'b1;
         in_first = (i == 0);
         in_power = PW'(pw[i]);
         in_chan = (i == 0) ? CH_W'(ch) : CH_W'($urandom);
         thr_alpha = (i == 0 || !wiggle) ? AW'(alpha) : AW'($urandom);
         @(negedge clk);
      end
      in_valid = 1'b0; in_first = 1'b0;
      repeat (4) @(negedge clk);
      chk(nout == ((len > H) ? len - H : 0), gaps ? "R9 count with stalls" : "R2 count",
          nout, (len > H) ? len - H : 0);
   endtask

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0 && out_det == 1'b0 && out_full == 1'b0, "R1 flags", out_valid, 0);
      chk(out_est == '0, "R1 estimate", out_est, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R5 boundary: ref cells 4, alpha 3.25 -> equality at 14, above at 15
      for (int i = 0; i < 60; i++) pw[i] = 4;
      pw[30] = 14; pw[45] = 15;
      run_line(60, 3, 52, 1'b0, 1'b0);
      chk(obs_det[30] == 1'b0, "R5 equality no detect", obs_det[30], 0);
      chk(obs_det[45] == 1'b1, "R5 one above detects", obs_det[45], 1);

      // R7 zero-Doppler line with spikes and alpha 0
      for (int i = 0; i < 40; i++) pw[i] = (i % 7 == 0) ? 50000 : 3;
      run_line(40, 0, 0, 1'b0, 1'b1);
      chk(obs_det[21] == 1'b0, "R7 spike suppressed", obs_det[21], 0);

      // R8 bright line followed by dim line
      for (int i = 0; i < 30; i++) pw[i] = 60000;
      run_line(30, 2, 16, 1'b0, 1'b0);
      for (int i = 0; i < 30; i++) pw[i] = 5;
      pw[3] = 400;
      run_line(30, 2, 16, 1'b0, 1'b0);

      // R10 alpha latched: high at start, wiggled to anything later
      for (int i = 0; i < 50; i++) pw[i] = 100;
      pw[30] = 300;
      run_line(50, 5, 255, 1'b0, 1'b1);
      chk(obs_det[30] == 1'b0, "R10 alpha from first cell", obs_det[30], 0);

      // R9 directed gaps with a clear target
      for (int i = 0; i < 50; i++) pw[i] = 10;
      pw[25] = 5000;
      run_line(50, 1, 32, 1'b1, 1'b0);
      chk(obs_det[25] == 1'b1, "R9 detect under stalls", obs_det[25], 1);

      // short line: only partial windows (R6)
      for (int i = 0; i < 12; i++) pw[i] = 1000 * i;
      run_line(12, 4, 0, 1'b0, 1'b0);

      // random lines
      for (int n = 0; n < 30; n++) begin
         int len;
         len = 17 + $urandom % 48;
         for (int i = 0; i < len; i++) begin
            if ($urandom % 10 == 0) pw[i] = 500 + $urandom % 4000;
            else if ($urandom % 40 == 0) pw[i] = 65535;
            else pw[i] = $urandom % 200;
         end
         run_line(len, $urandom % 8, $urandom % 256, n % 2 == 1, n % 3 == 0);
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         checks++; errors++;
         $display("FAIL watchdog expired actual=%0d expected=0", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule